// File: doc/BRIEF.md
# DMA Trigger Arbiter

This block sits in front of a three-channel DMA transfer engine and decides which channel moves data next. Each channel watches one line out of a wide vector of candidate request signals; the line is chosen by a per-channel select field. A rising edge on the chosen line becomes a pending request for that channel. A pending request stays latched until the channel is served. Several edges that arrive while a request is already pending count as one request.

While the memory bus is reserved (for example during register reprogramming or non-maskable interrupt service), the hold input is high and trigger edges are discarded. With several channels pending, one grant is issued at a time. The order is either fixed with channel 0 highest or rotating, where the channel served last drops to lowest. A one-cycle strobe and a one-hot grant start the engine. The grant stays up until the engine answers with a done pulse. Address and count generation live in the engine, not here.

Top module: `dma_trig_arb`

## Requirements
- R1: After reset, `grant` is 0, `grant_stb` is 0 and no channel holds a pending request.
- R2: Channel c (0..2) uses only source `src_req[sel_flat[4c+3:4c]]`; a rising edge there produces a grant on `grant` bit c and on no other bit.
- R3: With no grant outstanding, a rising edge first sampled at clock edge k gives `grant_stb`=1 and the grant bit after edge k+1, and not after edge k.
- R4: `grant_stb` is high for exactly one cycle per grant; `grant` is one-hot or zero and holds its value until `eng_done`.
- R5: `eng_done` sampled with a grant outstanding clears `grant` at that edge; the next grant appears no earlier than the following edge.
- R6: Rising edges sampled while `bus_hold`=1 are discarded; a source that rose during the hold and is still high afterwards causes no grant.
- R7: Any number of edges on a channel that is already pending result in a single grant.
- R8: With `rot_mode`=0, pending channels are served in the order 0, 1, 2.
- R9: With `rot_mode`=1, the search starts at the channel after the last granted one (wrapping 2 to 0); after reset the last granted channel counts as 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_req | input | 16 | Candidate trigger signals |
| sel_flat | input | 12 | Per-channel source select, 4 bits per channel, channel 0 in bits 3:0 |
| bus_hold | input | 1 | Bus reserved; trigger edges are discarded |
| rot_mode | input | 1 | 0 = fixed order, 1 = rotating order |
| eng_done | input | 1 | Transfer engine finished the granted transfer |
| grant | output | 3 | One-hot granted channel |
| grant_stb | output | 1 | One-cycle start pulse for a new grant |

## Verification
A wrong tap index or a wrong slice of the select field shows up as a grant on the wrong channel, or as no grant at all, two edges after the source rises. A pending bit that is lost, doubled or not masked by hold shows up within a few cycles. It appears as a missing grant, an extra grant after the expected sequence, or a grant after a hold window. A corrupted last-served register changes the order in the rotating sweep, which starts from every channel and covers every pending pattern. That error is therefore seen at the second grant of the affected case.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;
  localparam int CH_DEF  = 3;
  localparam int SRC_DEF = 16;
endpackage

// File: rtl/dma_trig_unit.sv
module dma_trig_unit #(
  parameter int NSRC = 16,
  localparam int SELW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic [NSRC-1:0] src,
  input  logic [SELW-1:0] sel,
  input  logic            hold,
  input  logic            clr,
  output logic            pend
);
  logic tap, prev_q, pend_q, pend_n, rise;

  assign tap  = src[sel];
  assign rise = tap & ~prev_q;

  always_comb begin
    pend_n = pend_q;
    if (clr)            pend_n = 1'b0;
    if (rise && !hold)  pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= tap;
      pend_q <= pend_n;
    end
  end

  assign pend = pend_q;

  // R6
  hold_block_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (hold && !pend_q) |=> !pend_q);
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int NCH = 3,
  localparam int IW = $clog2(NCH)
) (
  input  logic [NCH-1:0] pend,
  input  logic [IW-1:0]  last,
  input  logic           rot,
  output logic           any,
  output logic [IW-1:0]  win
);
  int base;
  int idx;

  always_comb begin
    any  = 1'b0;
    win  = '0;
    base = rot ? int'(last) : NCH - 1;
    idx  = 0;
    for (int i = 1; i <= NCH; i++) begin
      idx = base + i;
      if (idx >= NCH) idx = idx - NCH;
      if (!any && pend[idx]) begin
        any = 1'b1;
        win = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/dma_trig_arb.sv
module dma_trig_arb #(
  parameter int NCH  = dma_trig_pkg::CH_DEF,
  parameter int NSRC = dma_trig_pkg::SRC_DEF,
  localparam int SELW = $clog2(NSRC),
  localparam int IW   = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     src_req,
  input  logic [NCH*SELW-1:0] sel_flat,
  input  logic                bus_hold,
  input  logic                rot_mode,
  input  logic                eng_done,
  output logic [NCH-1:0]      grant,
  output logic                grant_stb
);
  logic [1:0]     rst_pipe;
  logic           arst_n;
  logic [NCH-1:0] pend, clr_vec;
  logic [NCH-1:0] grant_q, grant_n;
  logic           stb_q, stb_n, start, busy, any;
  logic [IW-1:0]  win, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign arst_n = rst_pipe[1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_trig_unit #(.NSRC(NSRC)) i_unit (
      .clk(clk), .arst_n(arst_n), .src(src_req),
      .sel(sel_flat[c*SELW +: SELW]), .hold(bus_hold),
      .clr(clr_vec[c]), .pend(pend[c]));
  end

  dma_arb_pick #(.NCH(NCH)) i_pick (
    .pend(pend), .last(last_q), .rot(rot_mode), .any(any), .win(win));

  assign busy = |grant_q;

  always_comb begin
    grant_n = grant_q;
    stb_n   = 1'b0;
    start   = 1'b0;
    if (busy) begin
      if (eng_done) grant_n = '0;
    end else if (any) begin
      start   = 1'b1;
      stb_n   = 1'b1;
      grant_n = NCH'(1) << win;
    end
  end

  assign clr_vec = grant_n & {NCH{start}};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      grant_q <= '0;
      stb_q   <= 1'b0;
      last_q  <= IW'(NCH - 1);
    end else begin
      grant_q <= grant_n;
      stb_q   <= stb_n;
      if (start) last_q <= win;
    end
  end

  assign grant     = grant_q;
  assign grant_stb = stb_q;

  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0(grant_q));
  // R4
  stb_fresh_chk: assert property (@(posedge clk) disable iff (!arst_n)
    stb_q |-> ($onehot(grant_q) && $past(grant_q) == '0));
  // R4
  grant_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (busy && !eng_done) |=> (grant_q == $past(grant_q)));
  // R5
  done_release_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (busy && eng_done) |=> (grant_q == '0 && !stb_q));
endmodule

// File: tb/test_dma_trig_arb.sv
`timescale 1ns/1ps
module test_dma_trig_arb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] src_req;
  logic [11:0] sel_flat;
  logic        bus_hold, rot_mode, eng_done;
  logic [2:0]  grant;
  logic        grant_stb;
  int nvec = 0;
  int nerr = 0;
  int last_m = 2;

  always #4 clk = ~clk;

  dma_trig_arb i_dma_trig_arb (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .sel_flat(sel_flat),
    .bus_hold(bus_hold), .rot_mode(rot_mode), .eng_done(eng_done),
    .grant(grant), .grant_stb(grant_stb));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pick(input int p, input int last, input bit r);
    int base = r ? last : 2;
    for (int i = 1; i <= 3; i++) begin
      int idx = (base + i) % 3;
      if (p[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic wait_stb(input int exp, input string req);
    int k = 0;
    while (grant_stb !== 1'b1 && k < 16) begin
      @(negedge clk);
      k++;
    end
    chk(grant_stb === 1'b1 && grant == 3'(1 << exp), req, int'(grant), 1 << exp);
    last_m = exp;
  endtask

  task automatic finish_xfer(input string req);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    chk(grant == 3'd0 && !grant_stb, req, int'(grant), 0);
  endtask

  task automatic idle(input int n, input string req);
    repeat (n) begin
      @(negedge clk);
      chk(grant == 3'd0 && !grant_stb, req, int'({grant_stb, grant}), 0);
    end
  endtask

  task automatic order_case(input int m, input bit r, input string req);
    int p = m;
    src_req[2:0] = 3'(m);
    while (p != 0) begin
      int w = pick(p, last_m, r);
      wait_stb(w, req);
      p = p & ~(1 << w);
      finish_xfer(req);
    end
    src_req = '0;
    idle(3, req);
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_req = '0; sel_flat = '0;
    bus_hold = 1'b0; rot_mode = 1'b0; eng_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: outputs quiet after reset, nothing pending
    idle(6, "R1");

    // R2, R3, R4, R5: sweep every channel over every source
    for (int c = 0; c < 3; c++) begin
      for (int s = 0; s < 16; s++) begin
        for (int o = 0; o < 3; o++)
          sel_flat[o*4 +: 4] = (o == c) ? 4'(s) : 4'((s + 1 + o) % 16);
        src_req[s] = 1'b1;
        @(negedge clk);
        chk(grant == 3'd0 && !grant_stb, "R3", int'(grant), 0);
        @(negedge clk);
        chk(grant_stb && grant == 3'(1 << c), "R3", int'(grant), 1 << c);
        @(negedge clk);
        chk(!grant_stb && grant == 3'(1 << c), "R4", int'({grant_stb, grant}), 1 << c);
        @(negedge clk);
        chk(grant == 3'(1 << c), "R4", int'(grant), 1 << c);
        src_req = '0;
        finish_xfer("R5");
        last_m = c;
        idle(3, "R2");
      end
    end

    // R8: fixed order over all pending patterns
    sel_flat = {4'd2, 4'd1, 4'd0};
    rot_mode = 1'b0;
    for (int m = 1; m < 8; m++) order_case(m, 1'b0, "R8");

    // R9: rotating order from every last-served channel
    rot_mode = 1'b1;
    for (int f = 0; f < 3; f++) begin
      for (int m = 1; m < 8; m++) begin
        src_req[f] = 1'b1;
        wait_stb(f, "R9");
        finish_xfer("R9");
        src_req = '0;
        idle(2, "R9");
        order_case(m, 1'b1, "R9");
      end
    end
    rot_mode = 1'b0;

    // R6: pulse during hold is dropped
    bus_hold = 1'b1;
    src_req[0] = 1'b1;
    @(negedge clk);
    src_req[0] = 1'b0;
    @(negedge clk);
    bus_hold = 1'b0;
    idle(6, "R6");
    // R6: level that rose during hold and stays high is dropped
    bus_hold = 1'b1;
    src_req[0] = 1'b1;
    repeat (2) @(negedge clk);
    bus_hold = 1'b0;
    idle(6, "R6");
    src_req[0] = 1'b0;
    @(negedge clk);
    src_req[0] = 1'b1;
    wait_stb(0, "R6");
    finish_xfer("R6");
    src_req = '0;
    idle(2, "R6");

    // R7: repeated edges while pending give one grant
    src_req[1] = 1'b1;
    wait_stb(1, "R7");
    repeat (3) begin
      src_req[0] = 1'b1;
      @(negedge clk);
      src_req[0] = 1'b0;
      @(negedge clk);
    end
    chk(grant == 3'd2, "R4", int'(grant), 2);
    finish_xfer("R7");
    src_req[1] = 1'b0;
    wait_stb(0, "R7");
    finish_xfer("R7");
    idle(6, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule